// File: doc/BRIEF.md
# Vector Status/Control Register Unit

This block holds the status and control word of a SIMD execution path. Every cycle it looks at one 32-bit instruction word, qualified by a valid strobe. It recognises two operations: a write that loads the register from a 128-bit source operand, and a read that returns the register as a 128-bit result addressed to a destination vector register. It also takes a per-cycle saturation pulse from the saturating vector lanes and holds it in a sticky flag. It drives the flush-to-zero mode bit to the floating-point lanes without interruption.

Only two bits of the register carry meaning: a flush-to-zero (non-IEEE) mode bit and a sticky saturation bit. A write draws both from the least significant 32-bit word of the operand, which holds bytes 12..15 in big-endian order. Every other bit is stored as zero. Writing an all-zero vector clears saturation and selects full IEEE denormal handling.

The interface has no back-pressure. Every instruction-valid cycle is accepted at once, and there is no ready signal. A read result appears for exactly one cycle, one clock after the read issues, and whoever receives it must take it in that cycle.

Top module: `vscr_unit`

## Requirements
- R1: A synchronous active-high reset clears the mode bit, the saturation bit and the result strobe.
- R2: A write is the word with bits 31:26 = 4 and bits 10:0 = 1604 (0x10000644 when its register fields are zero). The register fields in bits 25:11 may take any value. One cycle after the write issues, the mode output equals operand bit 15 and the saturation output equals operand bit 0. Operand bits 127:16 and 14:1 have no effect.
- R3: Nothing changes state unless the instruction-valid strobe is high and both opcode fields match.
- R4: A saturation pulse sets the saturation output on the following cycle. The flag then stays set until a write loads a new value.
- R5: When a write and a saturation pulse arrive in the same cycle, the saturation bit takes the value of the written operand.
- R6: The mode output always shows the stored mode bit, whatever instructions are issued.
- R7: A read is bits 31:26 = 4 with bits 10:0 = 1540 (0x10000604). One cycle after it issues, the result strobe is high for one cycle and carries the destination index from bits 25:21. The result is all zero except bit 15 (mode) and bit 0 (saturation).
- R8: A read issued in the cycle right after a write returns the written value, with no barrier in between.
- R9: A read leaves the stored bits unchanged.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction word |
| src_operand | input | 128 | Source vector operand for a write |
| sat_pulse | input | 1 | A saturating lane clipped a result this cycle |
| flush_mode | output | 1 | Flush-to-zero mode bit for the floating-point lanes |
| sat_sticky | output | 1 | Sticky saturation bit |
| rd_valid | output | 1 | Read result strobe |
| rd_dest | output | 5 | Destination vector register index of the result |
| rd_data | output | 128 | Read result vector |

## Verification
Two functions can act in the same cycle: a register write and a saturation pulse from the lanes. The bench drives both in one cycle with the saturation bit of the operand set to 1, and again with it set to 0. It then checks on the following cycle that the sticky output follows the operand in both cases. A separate case leaves a pulse on in the cycle before a write and checks that the write still clears the flag.

// File: rtl/vscr_pkg.sv
package vscr_pkg;
  localparam int INSTR_W   = 32;
  localparam int WORD_W    = 32;
  localparam int REG_IDX_W = 5;
  localparam logic [5:0]  PRIMARY_VEC   = 6'd4;
  localparam logic [10:0] XO_WRITE_STAT = 11'd1604;
  localparam logic [10:0] XO_READ_STAT  = 11'd1540;
  localparam int MODE_BIT = 15;
  localparam int SAT_BIT  = 0;

  typedef struct packed {
    logic mode;
    logic sat;
  } stat_t;
endpackage

// File: rtl/vscr_decode.sv
module vscr_decode
  import vscr_pkg::*;
(
  input  logic                 valid,
  input  logic [INSTR_W-1:0]   word,
  output logic                 wr_fire,
  output logic                 rd_fire,
  output logic [REG_IDX_W-1:0] dest_idx
);
  logic [5:0]  primary;
  logic [10:0] xo;
  logic        is_vec;

  always_comb begin
    primary  = word[31:26];
    xo       = word[10:0];
    is_vec   = valid && (primary == PRIMARY_VEC);
    wr_fire  = is_vec && (xo == XO_WRITE_STAT);
    rd_fire  = is_vec && (xo == XO_READ_STAT);
    dest_idx = word[25:21];
  end
endmodule

// File: rtl/vscr_state.sv
module vscr_state
  import vscr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_fire,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              sat_pulse,
  output stat_t             stat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
    end else if (wr_fire) begin
      stat.mode <= wr_word[MODE_BIT];
      stat.sat  <= wr_word[SAT_BIT];
    end else if (sat_pulse) begin
      stat.sat <= 1'b1;
    end
  end
endmodule

// File: rtl/vscr_readback.sv
module vscr_readback
  import vscr_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_fire,
  input  logic [REG_IDX_W-1:0] dest_idx,
  input  stat_t                stat,
  output logic                 rd_valid,
  output logic [REG_IDX_W-1:0] rd_dest,
  output logic [VEC_W-1:0]     rd_data
);
  logic [VEC_W-1:0] packed_vec;

  always_comb begin
    packed_vec           = '0;
    packed_vec[MODE_BIT] = stat.mode;
    packed_vec[SAT_BIT]  = stat.sat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_dest  <= '0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) begin
        rd_dest <= dest_idx;
        rd_data <= packed_vec;
      end
    end
  end
endmodule

// File: rtl/vscr_unit.sv
module vscr_unit
  import vscr_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 instr_valid,
  input  logic [INSTR_W-1:0]   instr_word,
  input  logic [VEC_W-1:0]     src_operand,
  input  logic                 sat_pulse,
  output logic                 flush_mode,
  output logic                 sat_sticky,
  output logic                 rd_valid,
  output logic [REG_IDX_W-1:0] rd_dest,
  output logic [VEC_W-1:0]     rd_data
);
  logic                 wr_fire;
  logic                 rd_fire;
  logic [REG_IDX_W-1:0] dest_idx;
  stat_t                stat;
  logic [WORD_W-1:0]    low_word;

  assign low_word = src_operand[WORD_W-1:0];

  vscr_decode u_decode (
    .valid    (instr_valid),
    .word     (instr_word),
    .wr_fire  (wr_fire),
    .rd_fire  (rd_fire),
    .dest_idx (dest_idx)
  );

  vscr_state u_state (
    .clk       (clk),
    .rst       (rst),
    .wr_fire   (wr_fire),
    .wr_word   (low_word),
    .sat_pulse (sat_pulse),
    .stat      (stat)
  );

  vscr_readback #(.VEC_W(VEC_W)) u_readback (
    .clk      (clk),
    .rst      (rst),
    .rd_fire  (rd_fire),
    .dest_idx (dest_idx),
    .stat     (stat),
    .rd_valid (rd_valid),
    .rd_dest  (rd_dest),
    .rd_data  (rd_data)
  );

  assign flush_mode = stat.mode;
  assign sat_sticky = stat.sat;
endmodule

// File: rtl/vscr_unit_chk.sv
module vscr_unit_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_fire,
  input logic             rd_fire,
  input logic [VEC_W-1:0] src_operand,
  input logic             sat_pulse,
  input logic             flush_mode,
  input logic             sat_sticky,
  input logic             rd_valid,
  input logic [VEC_W-1:0] rd_data
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!flush_mode && !sat_sticky && !rd_valid)); // R1
  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_fire |=> (flush_mode == $past(src_operand[15]) && sat_sticky == $past(src_operand[0]))); // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst) !wr_fire |=> $stable(flush_mode)); // R3
  AST_SAT_SET: assert property (@(posedge clk) disable iff (rst) (sat_pulse && !wr_fire) |=> sat_sticky); // R4
  AST_SAT_STICKY: assert property (@(posedge clk) disable iff (rst) (sat_sticky && !wr_fire) |=> sat_sticky); // R4
  AST_READ_STROBE: assert property (@(posedge clk) disable iff (rst) rd_fire |=> rd_valid); // R7
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) !rd_fire |=> !rd_valid); // R7
  AST_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_data[VEC_W-1:16] == '0 && rd_data[14:1] == '0)); // R7
endmodule

bind vscr_unit vscr_unit_chk #(.VEC_W(VEC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_fire     (wr_fire),
  .rd_fire     (rd_fire),
  .src_operand (src_operand),
  .sat_pulse   (sat_pulse),
  .flush_mode  (flush_mode),
  .sat_sticky  (sat_sticky),
  .rd_valid    (rd_valid),
  .rd_data     (rd_data)
);

// File: tb/vscr_unit_tb.sv
module vscr_unit_tb;
  localparam logic [31:0] WR = 32'h10000644;
  localparam logic [31:0] RD = 32'h10000604;
  localparam logic [95:0] ONES96 = {96{1'b1}};

  typedef struct packed {
    logic         valid;
    logic [31:0]  instr;
    logic [127:0] src;
    logic         pulse;
    logic         exp_mode;
    logic         exp_sat;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, WR,            {ONES96, 32'h00008001}, 1'b0, 1'b1, 1'b1}, // R2 load both
    '{1'b1, WR,            {ONES96, 32'h00000000}, 1'b0, 1'b0, 1'b0}, // R2 upper ignored
    '{1'b0, 32'h0,         128'h0,                 1'b1, 1'b0, 1'b1}, // R4 pulse sets
    '{1'b0, 32'h0,         128'h0,                 1'b0, 1'b0, 1'b1}, // R4 sticky
    '{1'b1, 32'h14000644,  128'h0,                 1'b0, 1'b0, 1'b1}, // R3 wrong primary
    '{1'b1, 32'h10000645,  128'h0,                 1'b0, 1'b0, 1'b1}, // R3 wrong xo
    '{1'b1, WR,            {ONES96, 32'hFFFF7FFE}, 1'b0, 1'b0, 1'b0}, // R2 other bits ignored
    '{1'b0, WR,            {96'h0, 32'h00008001},  1'b0, 1'b0, 1'b0}, // R3 not valid
    '{1'b1, 32'h13E05644,  {96'h0, 32'h00008000},  1'b0, 1'b1, 1'b0}, // R2 fields any
    '{1'b1, WR,            {96'h0, 32'h00000001},  1'b1, 1'b0, 1'b1}, // R5 both, write 1
    '{1'b1, WR,            128'h0,                 1'b1, 1'b0, 1'b0}  // R5 both, write 0
  };

  logic         clk = 1'b0;
  logic         rst;
  logic         instr_valid;
  logic [31:0]  instr_word;
  logic [127:0] src_operand;
  logic         sat_pulse;
  logic         flush_mode;
  logic         sat_sticky;
  logic         rd_valid;
  logic [4:0]   rd_dest;
  logic [127:0] rd_data;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vscr_unit u_dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .src_operand(src_operand), .sat_pulse(sat_pulse), .flush_mode(flush_mode),
    .sat_sticky(sat_sticky), .rd_valid(rd_valid), .rd_dest(rd_dest), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    instr_valid = 1'b0; instr_word = '0; src_operand = '0; sat_pulse = 1'b0;
  endtask

  task automatic step(input logic v, input logic [31:0] w, input logic [127:0] s, input logic p);
    instr_valid = v; instr_word = w; src_operand = s; sat_pulse = p;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; idle();
    @(negedge clk); @(negedge clk);
    check("R1 reset state", {rd_valid, flush_mode, sat_sticky}, 3'b000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].valid, VECS[i].instr, VECS[i].src, VECS[i].pulse);
      check($sformatf("R2/R3/R4/R5 row %0d", i), {flush_mode, sat_sticky},
            {VECS[i].exp_mode, VECS[i].exp_sat});
    end

    // R5: pulse the cycle before a write; write still clears
    step(1'b0, 32'h0, 128'h0, 1'b1);
    step(1'b1, WR, {ONES96, 32'h00008000}, 1'b0);
    check("R5 write after pulse", {flush_mode, sat_sticky}, 2'b10);

    // R7/R9: read returns mode only, dest 7, upper zero
    step(1'b1, RD | (32'd7 << 21), 128'h0, 1'b0);
    check("R7 read strobe", rd_valid, 1'b1);
    check("R7 read dest", rd_dest, 5'd7);
    check("R7 read data", rd_data, 128'h8000);
    check("R9 read keeps state", {flush_mode, sat_sticky}, 2'b10);
    @(negedge clk);
    check("R7 strobe one cycle", rd_valid, 1'b0);

    // R8: write immediately followed by read
    step(1'b1, WR, 128'h1, 1'b0);
    step(1'b1, RD | (32'd31 << 21), 128'h0, 1'b0);
    check("R8 back-to-back read data", rd_data, 128'h1);
    check("R8 back-to-back dest", rd_dest, 5'd31);

    // R6: mode output steady across pulses and reads
    step(1'b1, WR, 128'h8000, 1'b0);
    step(1'b0, 32'h0, 128'h0, 1'b1);
    step(1'b1, RD, 128'h0, 1'b1);
    check("R6 mode steady", flush_mode, 1'b1);
    check("R7 read sees pulse of prior cycle", rd_data, 128'h8001);

    // R1: reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset mid-run", {rd_valid, flush_mode, sat_sticky}, 3'b000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule